// File: doc/BRIEF.md
# Oversampled Serial Receiver with Start-Character Gate

This block receives asynchronous serial frames on a single line and stores them in a 16-entry receive queue. An external baud tick runs at the oversampled rate. A 3-bit field selects how many ticks make up one bit: 16, 8, 6, 4, or one tick per bit when oversampling is off. In the three widest ratios, each bit can be decided by a two-of-three vote taken around the middle of the bit. The frame has 7, 8 or 9 data bits, sent LSB first, followed by an optional even or odd parity bit and one stop bit. The line can be inverted before it reaches the receiver.

A gate can hold the receive path closed so that frames are dropped until one arrives whose data equals a programmed start character. That frame and every frame after it are stored. A start character of zero leaves the gate open. Each entry in the queue holds the data word together with a parity-error bit and a framing-error bit. Software-side logic pops one entry per read pulse. A level flag shows that the queue holds at least a programmed number of entries, and a sticky flag records any read from an empty queue.

Top module: `osr_uart_rx`

## Requirements
- R1: `osr_sel_i` 0, 1, 2 and 3 select 16, 8, 6 and 4 ticks per bit (5 to 7 act as 16). The first tick that sees the line low is phase 0 of the start bit. The middle sample is at phase N/2, and each bit is decided one tick after its middle sample.
- R2: `osr_sel_i` = 4 turns oversampling off: every tick is one bit period, and the bit is decided on that single tick's sample.
- R3: With `vote_en_i` = 1 and a ratio of 16, 8 or 6, each bit takes the majority of the samples at phases N/2-1, N/2 and N/2+1, so a one-tick disturbance at the middle is ignored. At ratio 4, or with `vote_en_i` = 0, the single sample at phase N/2 decides the bit.
- R4: `len_sel_i` 0, 1 and 2 select 7, 8 and 9 data bits (3 acts as 8). Bits are received LSB first, and `rd_data_o` bits above the frame length read 0.
- R5: `par_sel_i` 1 selects even parity and 2 selects odd parity; 0 and 3 mean no parity bit. The parity bit follows the data and does not count toward the frame length. `rd_perr_o` is 1 when the received parity does not match.
- R6: A low level at the stop-bit decision sample sets `rd_ferr_o` for that frame. The frame is still stored.
- R7: A start bit whose middle decision reads high is abandoned. No frame is stored, and the receiver returns to idle.
- R8: With `rx_inv_i` = 1 the line is inverted before the receiver, so the idle level on `rx_i` is low.
- R9: While `gate_en_i` = 1 and `start_val_i` is nonzero, frames are dropped until one with data equal to `start_val_i` arrives. That frame and all later ones are stored. Lowering `gate_en_i` re-arms the gate. When `start_val_i` is 0 the gate has no effect.
- R10: The queue holds 16 frames and returns them in arrival order. A frame that completes while the queue is full is dropped. A one-cycle `rd_en_i` pulse presents the oldest entry on the next cycle with `rd_valid_o` = 1.
- R11: `wm_level_o` is 1 when the occupancy is at least `wm_sel_i`+1 (1 to 16 frames).
- R12: A read of an empty queue gives `rd_valid_o` = 0 on the next cycle and sets `uflow_o`. `uflow_o` stays set until `uflow_clr_i` is pulsed.
- R13: A read in the same cycle as a frame write returns the older entry and leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line |
| tick_i | input | 1 | One-cycle pulse at the oversampled rate |
| osr_sel_i | input | 3 | Ticks-per-bit select |
| vote_en_i | input | 1 | Majority vote enable |
| len_sel_i | input | 2 | Data length select |
| par_sel_i | input | 2 | Parity select |
| rx_inv_i | input | 1 | Invert line before the receiver |
| gate_en_i | input | 1 | Start-character gate enable |
| start_val_i | input | 9 | Start character; 0 leaves the gate open |
| wm_sel_i | input | 4 | Level threshold minus one |
| rd_en_i | input | 1 | Pop request |
| uflow_clr_i | input | 1 | Clears the underflow flag |
| rd_data_o | output | 9 | Popped data word |
| rd_perr_o | output | 1 | Popped entry parity error |
| rd_ferr_o | output | 1 | Popped entry framing error |
| rd_valid_o | output | 1 | Popped entry valid |
| wm_level_o | output | 1 | Occupancy at or above threshold |
| uflow_o | output | 1 | Sticky empty-read flag |

## Verification
The two functions that can fall in the same cycle are a queue write and a queue read. A write happens in the cycle after a stop bit is decided, and a read can be requested in that same cycle. The bench counts ticks from the start-bit edge up to the stop-bit decision, then places the read pulse in the cycle where the write lands. It checks that the read returns the entry already held, that the level flag with threshold one stays raised, and that the next read returns the new frame followed by an underflow.

// File: rtl/osrx_pkg.sv
package osrx_pkg;
  localparam int unsigned DATA_W = 9;

  localparam logic [2:0] OSR_X16  = 3'd0;
  localparam logic [2:0] OSR_X8   = 3'd1;
  localparam logic [2:0] OSR_X6   = 3'd2;
  localparam logic [2:0] OSR_X4   = 3'd3;
  localparam logic [2:0] OSR_NONE = 3'd4;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  localparam logic [1:0] LEN_7 = 2'd0;
  localparam logic [1:0] LEN_9 = 2'd2;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_frame_t;

  // last phase index of a bit (ticks per bit minus one)
  function automatic logic [3:0] osr_last(input logic [2:0] sel);
    case (sel)
      OSR_X8:   return 4'd7;
      OSR_X6:   return 4'd5;
      OSR_X4:   return 4'd3;
      OSR_NONE: return 4'd0;
      default:  return 4'd15;
    endcase
  endfunction

  function automatic logic [3:0] osr_mid(input logic [2:0] sel);
    case (sel)
      OSR_X8:   return 4'd4;
      OSR_X6:   return 4'd3;
      OSR_X4:   return 4'd2;
      OSR_NONE: return 4'd0;
      default:  return 4'd8;
    endcase
  endfunction

  function automatic logic vote_allowed(input logic [2:0] sel);
    return !(sel == OSR_X4 || sel == OSR_NONE);
  endfunction

  function automatic logic [3:0] frame_bits(input logic [1:0] len);
    case (len)
      LEN_7:   return 4'd7;
      LEN_9:   return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/osrx_frame_rx.sv
module osrx_frame_rx
  import osrx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic [2:0] osr_sel_i,
  input  logic       vote_en_i,
  input  logic [1:0] len_sel_i,
  input  logic [1:0] par_sel_i,
  output logic       frame_valid_o,
  output rx_frame_t  frame_o
);
  rx_state_e         state_q;
  logic [3:0]        phase_q, idx_q;
  logic [1:0]        hist_q;
  logic [DATA_W-1:0] shreg_q;
  logic              pbit_q;

  logic [3:0] last, mid, nbits;
  logic       no_osr, use_vote, maj, smp, at_dec, par_on;

  always_comb begin
    last     = osr_last(osr_sel_i);
    mid      = osr_mid(osr_sel_i);
    nbits    = frame_bits(len_sel_i);
    no_osr   = (osr_sel_i == OSR_NONE);
    use_vote = vote_en_i && vote_allowed(osr_sel_i);
    // hist_q[1]: phase mid-1, hist_q[0]: phase mid, line_i: phase mid+1
    maj      = (hist_q[1] & hist_q[0]) | (hist_q[1] & line_i) | (hist_q[0] & line_i);
    smp      = no_osr ? line_i : (use_vote ? maj : hist_q[0]);
    at_dec   = tick_i && (no_osr || phase_q == mid + 4'd1);
    par_on   = (par_sel_i == PAR_EVEN) || (par_sel_i == PAR_ODD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      phase_q       <= '0;
      idx_q         <= '0;
      hist_q        <= 2'b11;
      shreg_q       <= '0;
      pbit_q        <= 1'b0;
      frame_valid_o <= 1'b0;
      frame_o       <= '0;
    end else begin
      frame_valid_o <= 1'b0;
      if (tick_i) hist_q <= {hist_q[0], line_i};
      if (tick_i && state_q != ST_IDLE) phase_q <= (phase_q == last) ? '0 : phase_q + 4'd1;
      case (state_q)
        ST_IDLE: if (tick_i && !line_i) begin
          shreg_q <= '0;
          idx_q   <= '0;
          if (no_osr) state_q <= ST_DATA;
          else begin
            state_q <= ST_START;
            phase_q <= 4'd1;
          end
        end
        ST_START: if (at_dec) state_q <= smp ? ST_IDLE : ST_DATA;
        ST_DATA: if (at_dec) begin
          shreg_q[idx_q] <= smp;
          if (idx_q == nbits - 4'd1) state_q <= par_on ? ST_PAR : ST_STOP;
          else idx_q <= idx_q + 4'd1;
        end
        ST_PAR: if (at_dec) begin
          pbit_q  <= smp;
          state_q <= ST_STOP;
        end
        ST_STOP: if (at_dec) begin
          frame_valid_o <= 1'b1;
          frame_o.data  <= shreg_q;
          frame_o.ferr  <= !smp;
          frame_o.perr  <= par_on && (^shreg_q ^ pbit_q ^ (par_sel_i == PAR_ODD));
          state_q       <= ST_IDLE;
          phase_q       <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_dec_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $past(tick_i));

  p_start_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) && at_dec && smp |=> (state_q == ST_IDLE) && !frame_valid_o);
endmodule

// File: rtl/osrx_start_gate.sv
module osrx_start_gate
  import osrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_en_i,
  input  logic [DATA_W-1:0] start_val_i,
  input  logic              frame_valid_i,
  input  logic [DATA_W-1:0] frame_data_i,
  output logic              push_o,
  output logic              blocked_o
);
  logic open_q, match;

  assign match     = (frame_data_i == start_val_i);
  assign blocked_o = gate_en_i && (start_val_i != '0) && !open_q;
  assign push_o    = frame_valid_i && (!blocked_o || match);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  open_q <= 1'b0;
    else if (!gate_en_i)                          open_q <= 1'b0;
    else if (blocked_o && frame_valid_i && match) open_q <= 1'b1;
  end

  p_gate_opens_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_o && frame_valid_i && match |=> !blocked_o || !gate_en_i);
endmodule

// File: rtl/osrx_fifo.sv
module osrx_fifo #(
  parameter  int unsigned DEPTH = 16,
  parameter  int unsigned W     = 11,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          rvalid_o,
  input  logic          uflow_clr_i,
  output logic          uflow_o,
  input  logic [AW-1:0] wm_i,
  output logic          level_o,
  output logic [AW:0]   count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   count_q;
  logic          full, empty, do_push, do_pop;

  assign full    = (count_q == (AW+1)'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign count_o = count_q;
  assign level_o = (count_q >= ({1'b0, wm_i} + (AW+1)'(1)));

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      count_q  <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      uflow_o  <= 1'b0;
    end else begin
      rvalid_o <= do_pop;
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop) begin
        rptr_q  <= rptr_q + 1'b1;
        rdata_o <= mem_q[rptr_q];
      end
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (pop_i && empty)   uflow_o <= 1'b1;
      else if (uflow_clr_i) uflow_o <= 1'b0;
    end
  end

  p_full_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full && !pop_i |=> count_q == $past(count_q));

  p_uflow_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty |=> uflow_o && !rvalid_o);

  p_uflow_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o && !uflow_clr_i |=> uflow_o);

  p_pushpop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !empty && !full |=> count_q == $past(count_q) && rvalid_o);
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osrx_pkg::*;
#(
  parameter  int unsigned FIFO_DEPTH  = 16,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned WM_W        = $clog2(FIFO_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic [2:0]        osr_sel_i,
  input  logic              vote_en_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic              rx_inv_i,
  input  logic              gate_en_i,
  input  logic [DATA_W-1:0] start_val_i,
  input  logic [WM_W-1:0]   wm_sel_i,
  input  logic              rd_en_i,
  input  logic              uflow_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o,
  output logic              rd_valid_o,
  output logic              wm_level_o,
  output logic              uflow_o
);
  localparam int unsigned FW = $bits(rx_frame_t);

  logic      line, frame_valid, push, blocked;
  rx_frame_t frame, rd_frame;
  logic [WM_W:0] fifo_count;

  // line synchronizer, resets to idle (high after optional inversion)
  generate
    if (SYNC_STAGES > 1) begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i ^ rx_inv_i};
      end
      assign line = sync_q[SYNC_STAGES-1];
    end else begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b1;
        else         sync_q <= rx_i ^ rx_inv_i;
      end
      assign line = sync_q;
    end
  endgenerate

  osrx_frame_rx u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .line_i        (line),
    .osr_sel_i     (osr_sel_i),
    .vote_en_i     (vote_en_i),
    .len_sel_i     (len_sel_i),
    .par_sel_i     (par_sel_i),
    .frame_valid_o (frame_valid),
    .frame_o       (frame)
  );

  osrx_start_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .gate_en_i     (gate_en_i),
    .start_val_i   (start_val_i),
    .frame_valid_i (frame_valid),
    .frame_data_i  (frame.data),
    .push_o        (push),
    .blocked_o     (blocked)
  );

  osrx_fifo #(.DEPTH(FIFO_DEPTH), .W(FW)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .wdata_i     (frame),
    .pop_i       (rd_en_i),
    .rdata_o     (rd_frame),
    .rvalid_o    (rd_valid_o),
    .uflow_clr_i (uflow_clr_i),
    .uflow_o     (uflow_o),
    .wm_i        (wm_sel_i),
    .level_o     (wm_level_o),
    .count_o     (fifo_count)
  );

  assign rd_data_o = rd_frame.data;
  assign rd_perr_o = rd_frame.perr;
  assign rd_ferr_o = rd_frame.ferr;

  p_blocked_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked && frame_valid && (frame.data != start_val_i) && !rd_en_i
    |=> fifo_count == $past(fifo_count));
endmodule

// File: tb/tb_osr_uart_rx.sv
module tb_osr_uart_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick;
  logic [2:0] osr_sel = 3'd0;
  logic       vote_en = 1'b0;
  logic [1:0] len_sel = 2'd1;
  logic [1:0] par_sel = 2'd0;
  logic       rx_inv = 1'b0;
  logic       gate_en = 1'b0;
  logic [8:0] start_val = '0;
  logic [3:0] wm_sel = '0;
  logic       rd_en = 1'b0;
  logic       uflow_clr = 1'b0;
  logic [8:0] rd_data;
  logic       rd_perr, rd_ferr, rd_valid, wm_level, uflow;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int cur_n = 16, cur_m = 8;
  logic [1:0] tcnt = '0;
  logic       sv_valid;
  logic [8:0] sv_data;

  always #5 clk = ~clk;
  always @(negedge clk) tcnt <= tcnt + 2'd1;
  assign tick = (tcnt == 2'd0);

  osr_uart_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick),
    .osr_sel_i(osr_sel), .vote_en_i(vote_en), .len_sel_i(len_sel), .par_sel_i(par_sel),
    .rx_inv_i(rx_inv), .gate_en_i(gate_en), .start_val_i(start_val), .wm_sel_i(wm_sel),
    .rd_en_i(rd_en), .uflow_clr_i(uflow_clr),
    .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr), .rd_valid_o(rd_valid),
    .wm_level_o(wm_level), .uflow_o(uflow)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_osr(input logic [2:0] s);
    osr_sel = s;
    case (s)
      3'd1: begin cur_n = 8; cur_m = 4; end
      3'd2: begin cur_n = 6; cur_m = 3; end
      3'd3: begin cur_n = 4; cur_m = 2; end
      3'd4: begin cur_n = 1; cur_m = 0; end
      default: begin cur_n = 16; cur_m = 8; end
    endcase
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (tick !== 1'b1);
  endtask

  // one bit period; level flipped during tick period gl_t only
  task automatic put_bit(input logic b, input int gl_t);
    for (int t = 0; t < cur_n; t++) begin
      wait_tick();
      #1 rx = ((t == gl_t) ? ~b : b) ^ rx_inv;
    end
  endtask

  task automatic send(input logic [8:0] v, input int nb, input int pm, input bit bad_par,
                      input bit bad_stop, input int gl_bit, input bit rd_at_stop);
    logic pb;
    pb = 1'b0;
    put_bit(1'b0, -1);
    for (int i = 0; i < nb; i++) begin
      put_bit(v[i], (i == gl_bit) ? cur_m : -1);
      pb = pb ^ v[i];
    end
    if (pm != 0) put_bit(pb ^ (pm == 2) ^ bad_par, -1);
    for (int t = 0; t < cur_n; t++) begin
      wait_tick();
      #1 rx = (!bad_stop) ^ rx_inv;
      if (rd_at_stop && t == cur_m + 2) begin
        rd_en = 1'b1;
        @(posedge clk);
        #1 rd_en = 1'b0;
        sv_valid = rd_valid;
        sv_data  = rd_data;
      end
    end
    put_bit(1'b1, -1);
    put_bit(1'b1, -1);
  endtask

  task automatic rd_check(input string req, input bit ev, input logic [8:0] ed,
                          input bit ep, input bit ef);
    @(posedge clk);
    #1 rd_en = 1'b1;
    @(posedge clk);
    #1 rd_en = 1'b0;
    chk(req, "rd_valid", rd_valid, ev);
    if (ev) begin
      chk(req, "rd_data", rd_data, ed);
      chk(req, "rd_perr", rd_perr, ep);
      chk(req, "rd_ferr", rd_ferr, ef);
    end
  endtask

  task automatic clr_uflow();
    @(posedge clk);
    #1 uflow_clr = 1'b1;
    @(posedge clk);
    #1 uflow_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "rd_valid after reset", rd_valid, 1'b0);
    chk("R11", "level after reset", wm_level, 1'b0);
    chk("R12", "uflow after reset", uflow, 1'b0);
  endtask

  task automatic t_ratios();
    logic [8:0] vals [5] = '{9'h0A5, 9'h03C, 9'h0E1, 9'h05A, 9'h0C3};
    for (int s = 0; s < 5; s++) begin
      set_osr(3'(s));
      send(vals[s], 8, 0, 0, 0, -1, 0);
      rd_check((s == 4) ? "R2" : "R1", 1'b1, vals[s], 1'b0, 1'b0);
    end
  endtask

  task automatic t_lengths();
    set_osr(3'd1);
    len_sel = 2'd0;
    send(9'h05B, 7, 0, 0, 0, -1, 0);
    rd_check("R4", 1'b1, 9'h05B, 1'b0, 1'b0);
    len_sel = 2'd2;
    send(9'h1A5, 9, 0, 0, 0, -1, 0);
    rd_check("R4", 1'b1, 9'h1A5, 1'b0, 1'b0);
    set_osr(3'd4);
    send(9'h10F, 9, 0, 0, 0, -1, 0);
    rd_check("R4", 1'b1, 9'h10F, 1'b0, 1'b0);
    len_sel = 2'd1;
  endtask

  task automatic t_parity();
    set_osr(3'd1);
    par_sel = 2'd1;
    send(9'h096, 8, 1, 0, 0, -1, 0);
    rd_check("R5", 1'b1, 9'h096, 1'b0, 1'b0);
    send(9'h097, 8, 1, 1, 0, -1, 0);
    rd_check("R5", 1'b1, 9'h097, 1'b1, 1'b0);
    par_sel = 2'd2;
    send(9'h037, 8, 2, 0, 0, -1, 0);
    rd_check("R5", 1'b1, 9'h037, 1'b0, 1'b0);
    send(9'h036, 8, 2, 1, 0, -1, 0);
    rd_check("R5", 1'b1, 9'h036, 1'b1, 1'b0);
    par_sel = 2'd0;
  endtask

  task automatic t_framing();
    set_osr(3'd1);
    send(9'h0C9, 8, 0, 0, 1, -1, 0);
    rd_check("R6", 1'b1, 9'h0C9, 1'b0, 1'b1);
    send(9'h012, 8, 0, 0, 0, -1, 0);
    rd_check("R6", 1'b1, 9'h012, 1'b0, 1'b0);
    rd_check("R6", 1'b0, 9'h000, 1'b0, 1'b0);
    clr_uflow();
  endtask

  task automatic t_false_start();
    set_osr(3'd0);
    wm_sel = 4'd0;
    put_bit(1'b1, -1);
    wait_tick(); #1 rx = 1'b0;
    wait_tick();
    wait_tick(); #1 rx = 1'b1;
    for (int i = 0; i < 3; i++) put_bit(1'b1, -1);
    chk("R7", "level after short low pulse", wm_level, 1'b0);
    rd_check("R7", 1'b0, 9'h000, 1'b0, 1'b0);
    chk("R12", "uflow set", uflow, 1'b1);
    repeat (20) @(posedge clk);
    #1 chk("R12", "uflow sticky", uflow, 1'b1);
    clr_uflow();
    chk("R12", "uflow cleared", uflow, 1'b0);
  endtask

  task automatic t_vote();
    vote_en = 1'b1;
    set_osr(3'd0);
    send(9'h000, 8, 0, 0, 0, 0, 0);
    rd_check("R3", 1'b1, 9'h000, 1'b0, 1'b0);
    set_osr(3'd1);
    send(9'h000, 8, 0, 0, 0, 0, 0);
    rd_check("R3", 1'b1, 9'h000, 1'b0, 1'b0);
    set_osr(3'd2);
    send(9'h080, 8, 0, 0, 0, 0, 0);
    rd_check("R3", 1'b1, 9'h080, 1'b0, 1'b0);
    set_osr(3'd3);
    send(9'h000, 8, 0, 0, 0, 0, 0);
    rd_check("R3", 1'b1, 9'h001, 1'b0, 1'b0);
    vote_en = 1'b0;
    set_osr(3'd0);
    send(9'h000, 8, 0, 0, 0, 0, 0);
    rd_check("R3", 1'b1, 9'h001, 1'b0, 1'b0);
  endtask

  task automatic t_invert();
    set_osr(3'd1);
    rx_inv = 1'b1;
    rx = 1'b0;
    put_bit(1'b1, -1);
    send(9'h0C5, 8, 0, 0, 0, -1, 0);
    rd_check("R8", 1'b1, 9'h0C5, 1'b0, 1'b0);
    rx_inv = 1'b0;
    rx = 1'b1;
    put_bit(1'b1, -1);
  endtask

  task automatic t_gate();
    set_osr(3'd1);
    gate_en = 1'b1;
    start_val = 9'h07E;
    send(9'h011, 8, 0, 0, 0, -1, 0);
    send(9'h07D, 8, 0, 0, 0, -1, 0);
    send(9'h07E, 8, 0, 0, 0, -1, 0);
    send(9'h022, 8, 0, 0, 0, -1, 0);
    rd_check("R9", 1'b1, 9'h07E, 1'b0, 1'b0);
    rd_check("R9", 1'b1, 9'h022, 1'b0, 1'b0);
    rd_check("R9", 1'b0, 9'h000, 1'b0, 1'b0);
    clr_uflow();
    gate_en = 1'b0;
    put_bit(1'b1, -1);
    gate_en = 1'b1;
    send(9'h044, 8, 0, 0, 0, -1, 0);
    rd_check("R9", 1'b0, 9'h000, 1'b0, 1'b0);
    clr_uflow();
    start_val = 9'h000;
    send(9'h033, 8, 0, 0, 0, -1, 0);
    rd_check("R9", 1'b1, 9'h033, 1'b0, 1'b0);
    gate_en = 1'b0;
  endtask

  task automatic t_fill();
    set_osr(3'd3);
    wm_sel = 4'd3;
    for (int i = 0; i < 17; i++) begin
      send(9'(i + 1), 8, 0, 0, 0, -1, 0);
      if (i == 2)  chk("R11", "level at 3 of 4", wm_level, 1'b0);
      if (i == 3) begin
        chk("R11", "level at 4 of 4", wm_level, 1'b1);
        wm_sel = 4'd15;
        #1 chk("R11", "level at 4 of 16", wm_level, 1'b0);
      end
      if (i == 14) chk("R11", "level at 15 of 16", wm_level, 1'b0);
      if (i == 15) chk("R11", "level at 16 of 16", wm_level, 1'b1);
    end
    for (int i = 0; i < 16; i++) rd_check("R10", 1'b1, 9'(i + 1), 1'b0, 1'b0);
    rd_check("R10", 1'b0, 9'h000, 1'b0, 1'b0);
    clr_uflow();
    wm_sel = 4'd0;
  endtask

  task automatic t_simul();
    set_osr(3'd1);
    wm_sel = 4'd0;
    send(9'h05A, 8, 0, 0, 0, -1, 0);
    send(9'h0A5, 8, 0, 0, 0, -1, 1);
    chk("R13", "read beside write valid", sv_valid, 1'b1);
    chk("R13", "read beside write data", sv_data, 9'h05A);
    chk("R13", "level kept", wm_level, 1'b1);
    rd_check("R13", 1'b1, 9'h0A5, 1'b0, 1'b0);
    rd_check("R13", 1'b0, 9'h000, 1'b0, 1'b0);
    clr_uflow();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_ratios();
    t_lengths();
    t_parity();
    t_framing();
    t_false_start();
    t_vote();
    t_invert();
    t_gate();
    t_fill();
    t_simul();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..R13 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule